// File: doc/BRIEF.md
# Multichannel ADC Burst Scan Sequencer

This block is an SPI master that collects one complete scan of a sequencing multichannel delta-sigma converter without processor help. A sample-rate trigger raises the conversion-start output. The block then waits for the first falling edge of the converter's data-ready line. From that point it clocks out fixed 40-bit read frames back to back in open loop and ignores any later data-ready edges.

Each received frame carries a status byte ahead of a 24-bit result. The status byte holds a fresh-data flag and a channel number. Frames without the flag are dropped. A fresh frame whose channel is enabled is written into that channel's slot of a result bank, which is read through a combinational select port. When every enabled channel has delivered a sample, the block sends one short register-write frame that rewrites the converter's first sequence register with 0xFF, which restarts the converter's channel sequence. It then releases chip select, lowers the start output and pulses `done`.

A frame budget bounds the scan and aborts it with an error flag. A rate check flags an SCLK divider too slow to fit two frames in one conversion period.

Top module: `adc_scan_seq`

## Requirements
- R1: `err_rate` is high exactly when 160 × (`sclk_div` + 1) is greater than `conv_period`, both counted in clock cycles. While it is high, `trig` is ignored and `adc_start` stays low.
- R2: An accepted `trig` drives `adc_start` high. `spi_cs_n` stays high and no SCLK edge occurs until the first falling edge of `adc_drdy_n`.
- R3: A read frame is 40 SCLK periods in SPI mode 0 with chip select low. MOSI sends `RD_CMD` (default 0x30) MSB first in the first 8 bits. MISO bits 8 to 15 are the status byte and bits 16 to 39 the 24-bit result, both MSB first. SCLK is low whenever chip select is high.
- R4: In the status byte, bit 7 is the fresh-data flag and bits 4:0 the channel number. A frame whose flag is clear changes no result and no overrun bit.
- R5: A fresh frame whose channel number is below 16 and enabled in `ch_en` stores its 24-bit result in that channel's slot, which `rd_data` shows when `rd_ch` selects it. Fresh frames for disabled or out-of-range channels leave every slot unchanged.
- R6: After the data-ready edge, read frames follow one another with chip select held low. No frame is sent after the one that completes the enabled set.
- R7: On completion the block sends exactly one 16-bit write frame, `WR_CMD` (default 0x68) then 0xFF. It then raises `spi_cs_n`, lowers `adc_start` and pulses `done` high for one cycle.
- R8: A second fresh sample for a channel in the same scan overwrites its slot and sets that channel's `overrun` bit. Overrun bits are only ever set for enabled channels and are cleared when the next trigger is accepted.
- R9: If `frame_limit` read frames pass without completion, the scan aborts. No write frame is sent and `done` does not pulse. Chip select is released, `adc_start` goes low, and `err_timeout` is set until the next accepted trigger.
- R10: Between scans `adc_start` is low and chip select is high. A new scan starts only on `trig`. A `trig` during a scan, or with `ch_en` equal to zero, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Sample-rate trigger pulse |
| ch_en | input | 16 | Channels required for a complete scan |
| frame_limit | input | 8 | Read-frame budget per scan (at least 1) |
| sclk_div | input | 8 | SCLK half period minus one, in clocks |
| conv_period | input | 16 | Converter conversion period, in clocks |
| rd_ch | input | 4 | Result bank read select |
| rd_data | output | 24 | Result of the selected channel |
| adc_start | output | 1 | Conversion-start output |
| adc_drdy_n | input | 1 | Data-ready from converter, active low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data to converter |
| spi_miso | input | 1 | SPI data from converter |
| done | output | 1 | One-cycle scan-complete pulse |
| err_timeout | output | 1 | Last scan aborted on frame budget |
| err_rate | output | 1 | Divider too slow for the conversion period |
| overrun | output | 16 | Channels captured more than once this scan |

## Verification
The bench builds the block with its default parameters: 16 channels, 24-bit results and 8-bit divider and budget fields. A divider of 0 makes each read frame 80 clocks long, so a full 16-channel scan and several aborted scans fit well inside the run. A frame budget of 4 makes the timeout path reachable after a few frames. Conversion periods of 159 and 160 sit on either side of the rate boundary, and a second divider value checks that the rate rule scales with the divider. The bench's converter model serves scripted status and result words, so stale frames, repeats, disabled and out-of-range channel numbers and an exhausted script all occur at chosen points of a scan.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_ARM     = 3'd1,
    S_RD_GO   = 3'd2,
    S_RD_WAIT = 3'd3,
    S_WR_GO   = 3'd4,
    S_WR_WAIT = 3'd5
  } scan_st_t;

  localparam int HDR_BITS = 8;
  localparam int STAT_BITS = 8;
  localparam int WR_BITS = 16;
  localparam logic [7:0] SEQ_RESET_VAL = 8'hFF;
endpackage

// File: rtl/drdy_sync.sv
module drdy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic fall
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= drdy_n;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall = s3 & ~s2;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int FW = 40,
  parameter int DIV_W = 8,
  parameter int RXW = FW - 8,
  localparam int LEN_W = $clog2(FW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] nbits,
  input  logic [FW-1:0]    tx,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [RXW-1:0]   rx,
  output logic             fin
);
  logic             act_q, act_d;
  logic             sclk_q, sclk_d;
  logic [DIV_W-1:0] hcnt_q, hcnt_d;
  logic [LEN_W-1:0] bcnt_q, bcnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [FW-1:0]    tsr_q, tsr_d;
  logic [RXW-1:0]   rsr_q, rsr_d;
  logic             fin_q, fin_d;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    hcnt_d = hcnt_q;
    bcnt_d = bcnt_q;
    len_d  = len_q;
    tsr_d  = tsr_q;
    rsr_d  = rsr_q;
    fin_d  = 1'b0;
    if (go && !act_q) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      hcnt_d = '0;
      bcnt_d = '0;
      len_d  = nbits;
      tsr_d  = tx;
    end else if (act_q) begin
      if (hcnt_q == div) begin
        hcnt_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rsr_d  = {rsr_q[RXW-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          tsr_d  = {tsr_q[FW-2:0], 1'b0};
          bcnt_d = bcnt_q + 1'b1;
          if (bcnt_q == len_q - 1'b1) begin
            act_d = 1'b0;
            fin_d = 1'b1;
          end
        end
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      len_q  <= '0;
      tsr_q  <= '0;
      rsr_q  <= '0;
      fin_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      hcnt_q <= hcnt_d;
      bcnt_q <= bcnt_d;
      len_q  <= len_d;
      tsr_q  <= tsr_d;
      rsr_q  <= rsr_d;
      fin_q  <= fin_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = tsr_q[FW-1];
  assign rx   = rsr_q;
  assign fin  = fin_q;

  // R3
  fin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> !sclk);
  // R3
  idle_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> !sclk_q);
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NCH = 16,
  parameter int DW = 24,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] rsel,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] slot [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot[g] <= '0;
      else if (we && (wsel == CW'(g))) slot[g] <= wdata;
    end
  end

  assign rdata = (int'(rsel) < NCH) ? slot[rsel] : '0;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int NCH = 16,
  parameter int DATA_W = 24,
  parameter int DIV_W = 8,
  parameter int PER_W = 16,
  parameter int LIM_W = 8,
  parameter logic [7:0] RD_CMD = 8'h30,
  parameter logic [7:0] WR_CMD = 8'h68
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig,
  input  logic [NCH-1:0]           ch_en,
  input  logic [LIM_W-1:0]         frame_limit,
  input  logic [DIV_W-1:0]         sclk_div,
  input  logic [PER_W-1:0]         conv_period,
  input  logic [$clog2(NCH)-1:0]   rd_ch,
  output logic [DATA_W-1:0]        rd_data,
  output logic                     adc_start,
  input  logic                     adc_drdy_n,
  output logic                     spi_cs_n,
  output logic                     spi_sclk,
  output logic                     spi_mosi,
  input  logic                     spi_miso,
  output logic                     done,
  output logic                     err_timeout,
  output logic                     err_rate,
  output logic [NCH-1:0]           overrun
);
  localparam int CW = $clog2(NCH);
  localparam int FW = HDR_BITS + STAT_BITS + DATA_W;
  localparam int RXW = FW - HDR_BITS;
  localparam int LEN_W = $clog2(FW + 1);
  localparam int RATE_K = 4 * FW;

  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  scan_st_t         st_q, st_d;
  logic [NCH-1:0]   en_q, en_d, got_q, got_d, ovr_q, ovr_d;
  logic [LIM_W-1:0] frm_q, frm_d;
  logic             err_q, err_d, done_q, done_d;
  logic             start_q, start_d, cs_q, cs_d;

  logic             drdy_fall, eng_go, eng_wr, eng_fin;
  logic [RXW-1:0]   eng_rx;
  logic [FW-1:0]    eng_tx;
  logic [LEN_W-1:0] eng_len;

  logic [7:0]       stat;
  logic [4:0]       id;
  logic [CW-1:0]    id_c;
  logic             hit, all_got, unused_rsv;
  logic [NCH-1:0]   hit_mask;
  logic [31:0]      rate_need;

  assign rate_need = 32'(RATE_K) * (32'(sclk_div) + 32'd1);
  assign err_rate  = rate_need > 32'(conv_period);

  assign stat       = eng_rx[DATA_W +: 8];
  assign id         = stat[4:0];
  assign id_c       = id[CW-1:0];
  assign unused_rsv = ^stat[6:5];
  assign hit        = eng_fin && (st_q == S_RD_WAIT) && stat[7] &&
                      (int'(id) < NCH) && en_q[id_c];
  assign hit_mask   = hit ? (NCH'(1) << id_c) : '0;
  assign all_got    = ((got_q | hit_mask) & en_q) == en_q;

  assign eng_tx  = eng_wr ? {WR_CMD, SEQ_RESET_VAL, {(FW-WR_BITS){1'b0}}}
                          : {RD_CMD, {(FW-HDR_BITS){1'b0}}};
  assign eng_len = eng_wr ? LEN_W'(WR_BITS) : LEN_W'(FW);

  always_comb begin
    st_d    = st_q;
    en_d    = en_q;
    got_d   = got_q;
    ovr_d   = ovr_q;
    frm_d   = frm_q;
    err_d   = err_q;
    start_d = start_q;
    cs_d    = cs_q;
    done_d  = 1'b0;
    eng_go  = 1'b0;
    eng_wr  = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (trig && !err_rate && (|ch_en)) begin
          st_d    = S_ARM;
          en_d    = ch_en;
          got_d   = '0;
          ovr_d   = '0;
          frm_d   = '0;
          err_d   = 1'b0;
          start_d = 1'b1;
        end
      end
      S_ARM: begin
        if (drdy_fall) begin
          st_d = S_RD_GO;
          cs_d = 1'b1;
        end
      end
      S_RD_GO: begin
        eng_go = 1'b1;
        st_d   = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (eng_fin) begin
          frm_d = frm_q + 1'b1;
          if (hit) begin
            got_d = got_q | hit_mask;
            ovr_d = ovr_q | (got_q & hit_mask);
          end
          if (all_got) begin
            st_d = S_WR_GO;
          end else if (({1'b0, frm_q} + 1'b1) >= {1'b0, frame_limit}) begin
            st_d    = S_IDLE;
            err_d   = 1'b1;
            cs_d    = 1'b0;
            start_d = 1'b0;
          end else begin
            st_d = S_RD_GO;
          end
        end
      end
      S_WR_GO: begin
        eng_go = 1'b1;
        eng_wr = 1'b1;
        st_d   = S_WR_WAIT;
      end
      S_WR_WAIT: begin
        if (eng_fin) begin
          st_d    = S_IDLE;
          cs_d    = 1'b0;
          start_d = 1'b0;
          done_d  = 1'b1;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= S_IDLE;
      en_q    <= '0;
      got_q   <= '0;
      ovr_q   <= '0;
      frm_q   <= '0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      en_q    <= en_d;
      got_q   <= got_d;
      ovr_q   <= ovr_d;
      frm_q   <= frm_d;
      err_q   <= err_d;
      start_q <= start_d;
      cs_q    <= cs_d;
      done_q  <= done_d;
    end
  end

  drdy_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_s),
    .drdy_n (adc_drdy_n),
    .fall   (drdy_fall)
  );

  spi_shift_engine #(.FW(FW), .DIV_W(DIV_W), .RXW(RXW)) u_eng (
    .clk   (clk),
    .rst_n (rst_s),
    .go    (eng_go),
    .nbits (eng_len),
    .tx    (eng_tx),
    .div   (sclk_div),
    .miso  (spi_miso),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .rx    (eng_rx),
    .fin   (eng_fin)
  );

  result_bank #(.NCH(NCH), .DW(DATA_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_s),
    .we    (hit),
    .wsel  (id_c),
    .wdata (eng_rx[DATA_W-1:0]),
    .rsel  (rd_ch),
    .rdata (rd_data)
  );

  assign adc_start   = start_q;
  assign spi_cs_n    = ~cs_q;
  assign done        = done_q;
  assign err_timeout = err_q;
  assign overrun     = ovr_q;

  // R3
  cs_sclk_chk: assert property (@(posedge clk) disable iff (!rst_s)
    spi_cs_n |-> !spi_sclk);
  // R10
  start_cs_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !adc_start |-> spi_cs_n);
  // R2
  arm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == S_ARM) |-> (spi_cs_n && adc_start));
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R7
  done_all_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> ((got_q & en_q) == en_q));
  // R8
  ovr_en_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (overrun & ~en_q) == '0);
  // R9
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(err_timeout) |-> (!done && spi_cs_n && !adc_start));
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  localparam logic [7:0] RDC = 8'h30;
  localparam logic [7:0] WRC = 8'h68;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [15:0] ch_en = '0;
  logic [7:0]  frame_limit = 8'd20;
  logic [7:0]  sclk_div = 8'd0;
  logic [15:0] conv_period = 16'd200;
  logic [3:0]  rd_ch = '0;
  logic [23:0] rd_data;
  logic        adc_start, adc_drdy_n, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic        done, err_timeout, err_rate;
  logic [15:0] overrun;

  always #4 clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .ch_en(ch_en),
    .frame_limit(frame_limit), .sclk_div(sclk_div), .conv_period(conv_period),
    .rd_ch(rd_ch), .rd_data(rd_data), .adc_start(adc_start),
    .adc_drdy_n(adc_drdy_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done),
    .err_timeout(err_timeout), .err_rate(err_rate), .overrun(overrun)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model: serves scripted {status, result} words on read frames
  logic [31:0] rq[$];
  logic [31:0] resp_w = '0;
  logic [15:0] msh = '0;
  int          bidx = 0;
  bit          is_rd = 0;
  int          rd_frames = 0, wr_frames = 0, bad_cmd = 0;
  logic [7:0]  wr_cmd_seen = '0, wr_dat_seen = '0;

  always @(posedge spi_sclk) begin
    msh = {msh[14:0], spi_mosi};
    bidx = bidx + 1;
    if (bidx == 8) begin
      if (msh[7:0] == RDC) begin
        is_rd = 1;
        resp_w = (rq.size() > 0) ? rq.pop_front() : 32'h0;
      end else begin
        is_rd = 0;
        if (msh[7:0] != WRC) bad_cmd++;
      end
    end
    if (is_rd && bidx == 40) begin
      rd_frames++;
      bidx = 0;
    end else if (!is_rd && bidx == 16) begin
      wr_frames++;
      wr_cmd_seen = msh[15:8];
      wr_dat_seen = msh[7:0];
      bidx = 0;
    end
  end

  assign spi_miso = (is_rd && bidx >= 8 && bidx < 40) ? resp_w[39 - bidx] : 1'b0;

  // per-clock comparison against the model
  logic [23:0] exp_res [16];
  bit cmp_on = 0;
  int inv_bad = 0, cmp_bad = 0, done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_cs_n && spi_sclk) inv_bad++;
      if (!adc_start && !spi_cs_n) inv_bad++;
      if (done) done_cnt++;
      if (cmp_on && rd_data !== exp_res[rd_ch]) cmp_bad++;
    end
  end

  logic [31:0] stage[$];

  task automatic do_scan(input logic [15:0] en, input logic [7:0] lim, input bit mid);
    int f0, w0, d0, fr, idx, n;
    logic [15:0] got, eo;
    bit comp;
    logic [23:0] nr [16];
    f0 = rd_frames; w0 = wr_frames; d0 = done_cnt;
    got = '0; eo = '0; fr = 0; idx = 0; comp = 0;
    nr = exp_res;
    while (1) begin
      logic [31:0] e;
      e = (idx < stage.size()) ? stage[idx] : 32'h0;
      idx++;
      fr++;
      if (e[31] && e[28:24] < 5'd16 && en[e[27:24]]) begin
        if (got[e[27:24]]) eo[e[27:24]] = 1'b1;
        nr[e[27:24]] = e[23:0];
        got[e[27:24]] = 1'b1;
      end
      if ((got & en) == en) begin comp = 1; break; end
      if (fr >= int'(lim)) break;
    end
    rq = stage;
    ch_en = en;
    frame_limit = lim;
    cmp_on = 0;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(adc_start == 1'b1, "R2 start raised", adc_start, 1);
    repeat (20) @(negedge clk);
    chk(spi_cs_n == 1'b1 && rd_frames == f0, "R2 quiet before data-ready", rd_frames - f0, 0);
    adc_drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    adc_drdy_n = 1'b1;
    if (mid) begin
      repeat (100) @(negedge clk);
      trig = 1'b1;
      @(negedge clk) trig = 1'b0;
    end
    n = 0;
    while (adc_start && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(0, "WDOG scan end", n, 0);
    repeat (5) @(negedge clk);
    chk(rd_frames - f0 == fr, "R6 read frame count", rd_frames - f0, fr);
    chk(wr_frames - w0 == (comp ? 1 : 0), "R7/R9 write frame count", wr_frames - w0, comp ? 1 : 0);
    chk(done_cnt - d0 == (comp ? 1 : 0), "R7/R9 done pulses", done_cnt - d0, comp ? 1 : 0);
    chk(err_timeout == !comp, "R9 timeout flag", err_timeout, !comp);
    chk(overrun == eo, "R8 overrun bits", overrun, eo);
    chk(spi_cs_n == 1'b1 && adc_start == 1'b0, "R10 idle after scan", {spi_cs_n, adc_start}, 2'b10);
    chk(bad_cmd == 0, "R3 command byte", bad_cmd, 0);
    if (comp) chk(wr_cmd_seen == WRC && wr_dat_seen == 8'hFF, "R7 write frame content",
                  {wr_cmd_seen, wr_dat_seen}, {WRC, 8'hFF});
    for (int c = 0; c < 16; c++) begin
      rd_ch = 4'(c);
      @(negedge clk);
      chk(rd_data == nr[c], $sformatf("R5 result ch%0d", c), rd_data, nr[c]);
    end
    rd_ch = '0;
    exp_res = nr;
    cmp_on = 1;
    repeat (30) @(negedge clk);
    chk(adc_start == 1'b0 && rd_frames - f0 == fr, "R10 no new scan without trigger", adc_start, 0);
  endtask

  initial begin
    adc_drdy_n = 1'b1;
    for (int c = 0; c < 16; c++) exp_res[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_start == 0 && spi_cs_n == 1 && spi_sclk == 0, "R10 reset outputs", {adc_start, spi_cs_n, spi_sclk}, 3'b010);
    chk(done == 0 && err_timeout == 0 && overrun == 0, "R9 reset flags", {done, err_timeout, overrun}, 0);
    chk(rd_data == 0, "R5 reset result", rd_data, 0);
    cmp_on = 1;

    // R1: rate boundary
    conv_period = 16'd159;
    #1;
    chk(err_rate == 1, "R1 rate error at 159", err_rate, 1);
    ch_en = 16'h0001;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (10) @(negedge clk);
    chk(adc_start == 0, "R1 trigger ignored on rate error", adc_start, 0);
    conv_period = 16'd160;
    #1;
    chk(err_rate == 0, "R1 rate ok at 160", err_rate, 0);
    sclk_div = 8'd1; conv_period = 16'd319;
    #1;
    chk(err_rate == 1, "R1 rate error div1", err_rate, 1);
    conv_period = 16'd320;
    #1;
    chk(err_rate == 0, "R1 rate ok div1", err_rate, 0);
    sclk_div = 8'd0; conv_period = 16'd200;

    // R10: empty mask ignored
    ch_en = 16'h0000;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (10) @(negedge clk);
    chk(adc_start == 0, "R10 trigger ignored with empty mask", adc_start, 0);

    // R4/R5/R6: stale frames, out-of-range id, mid-scan trigger
    stage = {32'h00_00_0001, 32'h80_A00001, 32'h94_777777, 32'h81_B00002,
             32'h02_FFFFFF, 32'h82_C00003, 32'h83_D00004};
    do_scan(16'h000F, 8'd20, 1);

    // R8/R5: repeat capture, disabled channel
    stage = {32'h80_111111, 32'h85_555555, 32'h80_222222, 32'h81_333333};
    do_scan(16'h0003, 8'd20, 0);

    // R9: budget exhausted
    stage = {32'h00_000000, 32'h01_000000, 32'h80_444444};
    do_scan(16'h0003, 8'd4, 0);

    // full mask, reverse channel order
    stage.delete();
    for (int c = 15; c >= 0; c--) stage.push_back({8'h80 | 8'(c), 24'h900000 + 24'(c)});
    do_scan(16'hFFFF, 8'd40, 0);

    chk(inv_bad == 0, "R3/R10 per-clock pin relations", inv_bad, 0);
    chk(cmp_bad == 0, "R5 per-clock result compare", cmp_bad, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule